// File: doc/BRIEF.md
# Isochronous OUT Double-Buffered Receive Store

This block holds the received payload of one isochronous OUT endpoint in two equal buffers, side A and side B. At any moment one side is the receive target and the other is handed to firmware for reading. Each start-of-frame pulse swaps the two roles, so firmware always reads the packet of the previous frame while the current frame's packet is stored.

A packet opens on an OUT-token pulse. It takes the side that is receiving at that moment, and it keeps that side until the end-of-packet strobe, even when a start-of-frame arrives in the middle. Each byte strobe stores one byte at the next address. The end-of-packet strobe carries a CRC-error flag from the packet decoder. At that strobe the block latches the stored byte count for the side. It then sets either the good-receive flag or the bad-receive flag of that side.

Firmware reads the count and the bytes of the side that is not receiving. It clears the status flags by writing ones.

Top module: `iso_out_pingpong`

## Requirements
- R1: After reset, side A (`rx_side` = 0) is the receive target, all four `status` bits are 0 and `rd_count` is 0.
- R2: Every cycle with `sof` high flips `rx_side` at that clock edge. Without `sof`, `rx_side` holds its value.
- R3: After an `out_tok` pulse, each `rx_valid` byte is stored at addresses 0, 1, 2, … in the side that was receiving at the token. `rd_data` returns the byte at `rd_addr` of the non-receiving side one cycle after `rd_addr` is applied.
- R4: `status` bit mapping is [0] good A, [1] bad A, [2] good B, [3] bad B. An end of packet with `eop_crc_err` = 0 and no dropped byte sets the good bit of the packet's side. The bit is visible after that clock edge.
- R5: An end of packet with `eop_crc_err` = 1 sets the bad bit of the packet's side.
- R6: Bytes beyond `max_pkt` are not stored (values above 128 act as 128). The latched count equals the number of bytes stored, and the packet sets the bad bit. With `max_pkt` = 0, no byte is stored and the count is 0.
- R7: `rd_count` shows the byte count latched at the last end of packet of the side that is not receiving.
- R8: A 1 in bit i of `clr_flags` clears `status` bit i (same mapping as R4). A set of the same bit in the same cycle wins over the clear.
- R9: Byte strobes and end-of-packet strobes that arrive while no packet is open change no stored byte, no count and no flag.
- R10: A start-of-frame arriving inside an open packet moves none of that packet's bytes. The whole packet lands in the side taken at its token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_pkt | input | 8 | Programmed maximum packet size in bytes |
| sof | input | 1 | Start-of-frame pulse |
| out_tok | input | 1 | OUT-token pulse, opens a packet |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| eop | input | 1 | End-of-packet strobe |
| eop_crc_err | input | 1 | Packet had a data error, valid with `eop` |
| clr_flags | input | 4 | Write-one-to-clear for the status bits |
| rd_addr | input | 7 | Firmware read address in the non-receiving side |
| rd_data | output | 8 | Byte read, one cycle after `rd_addr` |
| rd_count | output | 8 | Latched byte count of the non-receiving side |
| rx_side | output | 1 | Receiving side, 0 = A, 1 = B |
| status | output | 4 | Good/bad flags per side |

## Verification
Several results are due one edge after their stimulus:
- The flags and the count of a packet appear at the clock edge that samples `eop`.
- `rx_side` flips at the edge that samples `sof`.
- `rd_data` follows `rd_addr` by one edge.

The bench drives every input on the falling edge. It samples outputs on the following falling edge, which is after exactly one rising edge, so each check lands in the first cycle in which its value is due. Reads are issued only after the start-of-frame that hands the packet's side to the read port.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;
    localparam int unsigned DATA_W_DEF = 8;
    localparam int unsigned DEPTH_DEF  = 128;
    localparam int unsigned NSIDE      = 2;
    // status bit positions, shared by status and clr_flags
    localparam int unsigned FLG_GOOD = 0;
    localparam int unsigned FLG_BAD  = 1;
    localparam int unsigned FLG_PER_SIDE = 2;
endpackage

// File: rtl/iso_pp_wr_ctrl.sv
module iso_pp_wr_ctrl #(
    parameter int unsigned DEPTH = iso_pp_pkg::DEPTH_DEF,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1),
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             rx_side,
    input  logic             out_tok,
    input  logic             rx_valid,
    input  logic             eop,
    input  logic             crc_err,
    output logic             wr_en,
    output logic             wr_side,
    output logic [AW-1:0]    wr_addr,
    output logic             done,
    output logic             done_side,
    output logic             done_bad,
    output logic [CNT_W-1:0] done_cnt
);
    typedef struct packed {
        logic             open;
        logic             side;
        logic             ovf;
        logic [CNT_W-1:0] ptr;
    } pkt_t;

    pkt_t pkt_d, pkt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] ptr_n;
    logic             ovf_n;

    always_comb begin
        limit = (max_pkt > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : max_pkt;
        pkt_d    = pkt_q;
        wr_en    = 1'b0;
        done     = 1'b0;
        done_bad = 1'b0;
        ptr_n    = pkt_q.ptr;
        ovf_n    = pkt_q.ovf;
        if (out_tok) begin
            pkt_d.open = 1'b1;
            pkt_d.side = rx_side;
            pkt_d.ovf  = 1'b0;
            pkt_d.ptr  = '0;
        end else if (pkt_q.open) begin
            if (rx_valid) begin
                if (pkt_q.ptr < limit) begin
                    wr_en = 1'b1;
                    ptr_n = pkt_q.ptr + 1'b1;
                end else begin
                    ovf_n = 1'b1;
                end
            end
            if (eop) begin
                done       = 1'b1;
                done_bad   = crc_err | ovf_n;
                pkt_d.open = 1'b0;
            end
            pkt_d.ptr = ptr_n;
            pkt_d.ovf = ovf_n;
        end
        done_cnt  = ptr_n;
        wr_addr   = pkt_q.ptr[AW-1:0];
        wr_side   = pkt_q.side;
        done_side = pkt_q.side;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pkt_q <= '0;
        else        pkt_q <= pkt_d;
    end

    // R6
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (CNT_W'(wr_addr) < max_pkt));
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_cnt <= max_pkt));
    // R10
    side_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !out_tok) |=> (out_tok || !wr_en || $stable(wr_side)));
endmodule

// File: rtl/iso_pp_flags.sv
module iso_pp_flags
    import iso_pp_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          done,
    input  logic                          done_side,
    input  logic                          done_bad,
    input  logic [NSIDE*FLG_PER_SIDE-1:0] clr,
    output logic [NSIDE*FLG_PER_SIDE-1:0] flags
);
    localparam int unsigned NF = NSIDE * FLG_PER_SIDE;

    typedef struct packed {
        logic [NF-1:0] flg;
    } flg_t;

    flg_t f_d, f_q;
    logic [NF-1:0] set;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        assign set[g*FLG_PER_SIDE + FLG_GOOD] = done && (done_side == 1'(g)) && !done_bad;
        assign set[g*FLG_PER_SIDE + FLG_BAD]  = done && (done_side == 1'(g)) &&  done_bad;
    end

    always_comb begin
        f_d.flg = (f_q.flg & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q.flg;

    for (genvar i = 0; i < NF; i++) begin : g_chk
        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
        // R8
        clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/iso_pp_mem.sv
module iso_pp_mem #(
    parameter int unsigned DATA_W = iso_pp_pkg::DATA_W_DEF,
    parameter int unsigned DEPTH  = iso_pp_pkg::DEPTH_DEF,
    parameter int unsigned AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_side,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] bank_rd [iso_pp_pkg::NSIDE];
    logic [DATA_W-1:0] rd_d, rd_q;

    for (genvar b = 0; b < iso_pp_pkg::NSIDE; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_side == 1'(b))) mem[wr_addr] <= wr_data;
        end
        assign bank_rd[b] = mem[rd_addr];
    end

    always_comb rd_d = bank_rd[rd_side];

    always_ff @(posedge clk) rd_q <= rd_d;

    assign rd_data = rd_q;
endmodule

// File: rtl/iso_out_pingpong.sv
module iso_out_pingpong
    import iso_pp_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned NF    = NSIDE * FLG_PER_SIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  max_pkt,
    input  logic              sof,
    input  logic              out_tok,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              eop,
    input  logic              eop_crc_err,
    input  logic [NF-1:0]     clr_flags,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_count,
    output logic              rx_side,
    output logic [NF-1:0]     status
);
    typedef struct packed {
        logic                        side;
        logic [NSIDE-1:0][CNT_W-1:0] cnt;
    } top_t;

    top_t t_d, t_q;

    logic             wr_en, wr_side, done, done_side, done_bad;
    logic [AW-1:0]    wr_addr;
    logic [CNT_W-1:0] done_cnt;

    iso_pp_wr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_wr (
        .clk, .rst_n, .max_pkt, .rx_side(t_q.side), .out_tok, .rx_valid,
        .eop, .crc_err(eop_crc_err), .wr_en, .wr_side, .wr_addr,
        .done, .done_side, .done_bad, .done_cnt
    );

    iso_pp_flags u_flg (
        .clk, .rst_n, .done, .done_side, .done_bad,
        .clr(clr_flags), .flags(status)
    );

    iso_pp_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk, .wr_en, .wr_side, .wr_addr, .wr_data(rx_data),
        .rd_side(~t_q.side), .rd_addr, .rd_data
    );

    always_comb begin
        t_d = t_q;
        if (sof) t_d.side = ~t_q.side;
        if (done) t_d.cnt[done_side] = done_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rx_side  = t_q.side;
    assign rd_count = t_q.cnt[~t_q.side];

    // R2
    side_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (rx_side != $past(rx_side)));
    // R2
    side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(rx_side));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !sof) |=> $stable(rd_count));
endmodule

// File: tb/iso_out_pingpong_tb.sv
`timescale 1ns/1ps
module iso_out_pingpong_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] max_pkt = 8'd128;
    logic       sof = 0, out_tok = 0, rx_valid = 0, eop = 0, eop_crc_err = 0;
    logic [7:0] rx_data = 0;
    logic [3:0] clr_flags = 0;
    logic [6:0] rd_addr = 0;
    logic [7:0] rd_data, rd_count;
    logic       rx_side;
    logic [3:0] status;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    iso_out_pingpong u_dut (
        .clk, .rst_n, .max_pkt, .sof, .out_tok, .rx_valid, .rx_data,
        .eop, .eop_crc_err, .clr_flags, .rd_addr, .rd_data, .rd_count,
        .rx_side, .status
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic pulse_sof();
        sof = 1; tick(); sof = 0;
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base, input bit err,
                            input logic [3:0] clr_at_end);
        out_tok = 1; tick(); out_tok = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = base + 8'(i); tick();
        end
        rx_valid = 0;
        eop = 1; eop_crc_err = err; clr_flags = clr_at_end; tick();
        eop = 0; eop_crc_err = 0; clr_flags = 0;
    endtask

    task automatic clear_all();
        clr_flags = 4'hF; tick(); clr_flags = 0;
    endtask

    task automatic read_chk(input int addr, input logic [7:0] exp, input string req);
        rd_addr = 7'(addr); tick();
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic t_reset();
        chk(rx_side == 0, "R1 side", rx_side, 0);
        chk(status == 0, "R1 status", status, 0);
        chk(rd_count == 0, "R1 count", rd_count, 0);
    endtask

    task automatic t_good();
        send_pkt(5, 8'h10, 0, 4'h0);
        chk(status == 4'b0001, "R4 good A", status, 4'b0001);
        chk(rd_count == 0, "R7 count B before swap", rd_count, 0);
        pulse_sof();
        chk(rx_side == 1, "R2 flip to B", rx_side, 1);
        chk(rd_count == 5, "R7 count A", rd_count, 5);
        for (int i = 0; i < 5; i++) read_chk(i, 8'h10 + 8'(i), "R3 data A");
    endtask

    task automatic t_crc();
        send_pkt(3, 8'h40, 1, 4'h0);
        chk(status == 4'b1001, "R5 bad B", status, 4'b1001);
        pulse_sof();
        chk(rx_side == 0, "R2 flip to A", rx_side, 0);
        chk(rd_count == 3, "R7 count B", rd_count, 3);
        for (int i = 0; i < 3; i++) read_chk(i, 8'h40 + 8'(i), "R3 data B");
    endtask

    task automatic t_clear();
        clr_flags = 4'b0001; tick(); clr_flags = 0;
        chk(status == 4'b1000, "R8 clear good A", status, 4'b1000);
        send_pkt(2, 8'h60, 0, 4'b1001);
        chk(status == 4'b0001, "R8 set wins, bad B cleared", status, 4'b0001);
    endtask

    task automatic t_overflow();
        clear_all();
        max_pkt = 8'd4;
        send_pkt(6, 8'h70, 0, 4'h0);
        chk(status == 4'b0010, "R6 overflow bad A", status, 4'b0010);
        pulse_sof();
        chk(rd_count == 4, "R6 count clipped", rd_count, 4);
        for (int i = 0; i < 4; i++) read_chk(i, 8'h70 + 8'(i), "R6 stored bytes");
        read_chk(4, 8'h14, "R6 dropped byte not written");
        clear_all();
        max_pkt = 8'd0;
        send_pkt(3, 8'h90, 0, 4'h0);
        chk(status == 4'b1000, "R6 zero max bad B", status, 4'b1000);
        pulse_sof();
        chk(rd_count == 0, "R6 zero count", rd_count, 0);
        read_chk(0, 8'h40, "R6 zero max no write");
        max_pkt = 8'd128;
    endtask

    task automatic t_stray();
        clear_all();
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1; rx_data = 8'hEE; tick();
        end
        rx_valid = 0;
        eop = 1; tick(); eop = 0; tick();
        chk(status == 0, "R9 stray eop no flag", status, 0);
        pulse_sof();
        chk(rd_count == 4, "R9 count A unchanged", rd_count, 4);
        read_chk(0, 8'h70, "R9 data A unchanged");
    endtask

    task automatic t_midsof();
        out_tok = 1; tick(); out_tok = 0;
        for (int i = 0; i < 2; i++) begin
            rx_valid = 1; rx_data = 8'hA0 + 8'(i); tick();
        end
        rx_valid = 0;
        pulse_sof();
        chk(rx_side == 0, "R10 side moved to A", rx_side, 0);
        for (int i = 2; i < 4; i++) begin
            rx_valid = 1; rx_data = 8'hA0 + 8'(i); tick();
        end
        rx_valid = 0;
        eop = 1; tick(); eop = 0;
        chk(status == 4'b0100, "R10 good B", status, 4'b0100);
        chk(rd_count == 4, "R10 count B", rd_count, 4);
        for (int i = 0; i < 4; i++) read_chk(i, 8'hA0 + 8'(i), "R10 data B");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_good();
        t_crc();
        t_clear();
        t_overflow();
        t_stray();
        t_midsof();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule